// File: doc/BRIEF.md
# Link Auto-Negotiation Arbiter

This block settles the operating speed and duplex of a 10/100 Ethernet port. It exchanges 16-bit link code words with the far end and watches for plain idle traffic. It then reports the result. The pulse-level coding on the wire sits outside the block. So does the path that reaches the control bits. The block sees only decoded events: a strobe carrying a received code word, a 10BASE-T idle detect, a 100BASE-TX idle detect, and a link-loss pulse. It drives out the code word to transmit.

Negotiation is on when reset ends and starts at once. While it runs, the block counts runs of identical received words. The first run of three identical words is compared with the acknowledge bit masked off. It stores the partner's word and turns on the acknowledge bit in the outgoing word. A second run of three identical words must all carry acknowledge. When it completes, the block picks the best mode both ends share. If either idle pattern appears first, the block settles at once on half duplex at that speed. A missing common mode or a timeout raises a failure flag and starts the exchange over.

The four ability bits that the block advertises are seeded from a 3-bit strap during reset. After that, software can only clear them.

Top module: `linkNegArbiter`

## Requirements
- R1: While reset is active and after it is released, negotiation is enabled and running, negDone and negFail are 0, linkSpeed100 and linkFull are 0, partnerWord is 0, and txWord bit 14 (acknowledge) is 0.
- R2: txWord is {1'b0, ack, 5'b0, ability[3:0], 5'b00001}. The ability bits are 0 = 10BASE-T half, 1 = 10BASE-T full, 2 = 100BASE-TX half and 3 = 100BASE-TX full. At reset they load {s2&s1, s2, s0&s1, s0} from strap s. Strap 111 gives 1111 and strap 001 gives 0001.
- R3: An advertisement write with advWrEn makes ability <= ability & advWrData. A bit that is 0 never returns to 1 before the next reset.
- R4: In the first phase, three consecutive received words that are equal outside bit 14 are latched into partnerWord one cycle after the third strobe. From that cycle on, txWord bit 14 is 1.
- R5: A received word that differs from the previous one restarts the run at a count of one. Only runs of consecutive equal words count.
- R6: In the second phase, three consecutive equal words that each have bit 14 set complete negotiation one cycle after the third strobe. negDone becomes 1, and linkSpeed100/linkFull give the best shared mode in the order 100 full, 100 half, 10 full, 10 half. The shared mode is the advertised ability ANDed with partnerWord bits 8:5. In this phase a word without bit 14 resets the run to zero.
- R7: While negotiating, an idle10 or idle100 pulse completes negotiation on the next cycle with linkFull 0. linkSpeed100 equals idle100, so 100 wins if both are seen.
- R8: If the second phase completes with no shared ability, negFail becomes 1, negDone stays 0, partnerWord and the acknowledge bit clear, and negotiation restarts.
- R9: If negotiation has not completed TIMEOUT_CYCLES cycles after it started, negFail becomes 1 and the exchange restarts with a fresh timer.
- R10: A linkLoss pulse, or a control write with ctlRestart 1 and ctlAnEn 1, restarts negotiation. negDone, negFail, the result bits, partnerWord and the acknowledge bit all clear on the next cycle.
- R11: A control write with ctlAnEn 0 stops negotiation: negDone 0, received words and idles are ignored, and there is no timeout. A later write with ctlAnEn 1 starts a fresh negotiation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strap | input | 3 | Ability seed sampled during reset |
| ctlWrEn | input | 1 | Control write strobe |
| ctlAnEn | input | 1 | Negotiation enable value for a control write |
| ctlRestart | input | 1 | Restart request for a control write |
| advWrEn | input | 1 | Advertisement write strobe |
| advWrData | input | 4 | Ability mask; only clears bits |
| rxWordValid | input | 1 | A received code word is present |
| rxWord | input | 16 | Received code word |
| idle10 | input | 1 | 10BASE-T idle detected |
| idle100 | input | 1 | 100BASE-TX idle detected |
| linkLoss | input | 1 | Link lost |
| txWord | output | 16 | Code word to transmit |
| partnerWord | output | 16 | Latched partner code word |
| negDone | output | 1 | Negotiation complete |
| negFail | output | 1 | Negotiation failed and restarted |
| linkSpeed100 | output | 1 | Result speed, 1 = 100 Mb/s |
| linkFull | output | 1 | Result duplex, 1 = full |

## Verification
The bench builds the block with TIMEOUT_CYCLES set to 60 and keeps the default run length of three. A whole negotiation takes about a dozen cycles, so it fits well inside the window. A silent exchange therefore reaches the timeout failure and its restart within a short run, which would be out of reach with the large default. The strap is applied twice, once as 111 and once as 001, to cover both seed patterns.

// File: rtl/lnkNegPkg.sv
package lnkNegPkg;
  localparam int WORD_W = 16;
  localparam int ACK_BIT = 14;
  localparam int ABIL_LO = 5;
  localparam int ABIL_W = 4;
  localparam logic [4:0] SELECTOR = 5'b00001;
  localparam logic [WORD_W-1:0] ACK_MASK = WORD_W'(1) << ACK_BIT;

  typedef enum logic [1:0] {ST_OFF, ST_SEEK, ST_ACK, ST_DONE} negState_t;

  typedef struct packed {
    logic restart;
    logic cntSeek;
    logic cntAck;
  } dpCmd_t;
endpackage

// File: rtl/lnkNegData.sv
module lnkNegData
  import lnkNegPkg::*;
#(
  parameter int RUN_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        strap,
  input  logic              advWrEn,
  input  logic [ABIL_W-1:0] advWrData,
  input  logic              rxWordValid,
  input  logic [WORD_W-1:0] rxWord,
  input  dpCmd_t            cmd,
  output logic              runHit,
  output logic              hasCommon,
  output logic              best100,
  output logic              bestFull,
  output logic [WORD_W-1:0] txWord,
  output logic [WORD_W-1:0] partnerWord
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic [ABIL_W-1:0] adv;
  logic [ABIL_W-1:0] common;
  logic [CNT_W-1:0]  runCnt, nextCnt;
  logic [WORD_W-1:0] lastWord;
  logic              ackOn, wordSame, qualify, counting;

  function automatic logic [ABIL_W-1:0] seedAdv(input logic [2:0] s);
    return {s[2] & s[1], s[2], s[0] & s[1], s[0]};
  endfunction

  assign wordSame = (rxWord & ~ACK_MASK) == (lastWord & ~ACK_MASK);
  assign qualify  = cmd.cntSeek | (cmd.cntAck & rxWord[ACK_BIT]);
  assign counting = rxWordValid & (cmd.cntSeek | cmd.cntAck);

  always_comb begin
    if (!qualify) nextCnt = '0;
    else if (runCnt != '0 && wordSame) nextCnt = runCnt + CNT_W'(1);
    else nextCnt = CNT_W'(1);
  end

  assign runHit = counting & qualify & (nextCnt == CNT_W'(RUN_LEN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adv <= seedAdv(strap);
    end else if (advWrEn) begin
      adv <= adv & advWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt      <= '0;
      lastWord    <= '0;
      partnerWord <= '0;
      ackOn       <= 1'b0;
    end else if (cmd.restart) begin
      runCnt      <= '0;
      lastWord    <= '0;
      partnerWord <= '0;
      ackOn       <= 1'b0;
    end else if (counting) begin
      runCnt   <= runHit ? '0 : nextCnt;
      lastWord <= rxWord;
      if (runHit && cmd.cntSeek) begin
        partnerWord <= rxWord;
        ackOn       <= 1'b1;
      end
    end
  end

  assign common    = adv & partnerWord[ABIL_LO +: ABIL_W];
  assign hasCommon = |common;

  always_comb begin
    best100  = 1'b0;
    bestFull = 1'b0;
    if (common[3]) begin
      best100  = 1'b1;
      bestFull = 1'b1;
    end else if (common[2]) begin
      best100  = 1'b1;
    end else if (common[1]) begin
      bestFull = 1'b1;
    end
  end

  assign txWord = {1'b0, ackOn, 5'b00000, adv, SELECTOR};
endmodule

// File: rtl/lnkNegCtrl.sv
module lnkNegCtrl
  import lnkNegPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   ctlWrEn,
  input  logic   ctlAnEn,
  input  logic   ctlRestart,
  input  logic   linkLoss,
  input  logic   idle10,
  input  logic   idle100,
  input  logic   runHit,
  input  logic   hasCommon,
  input  logic   best100,
  input  logic   bestFull,
  output dpCmd_t cmd,
  output logic   negDone,
  output logic   negFail,
  output logic   linkSpeed100,
  output logic   linkFull
);
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);

  negState_t      st;
  logic [TMR_W-1:0] timer;
  logic anEn, newEn, restartReq, anyIdle, negotiating, active;
  logic timedOut, ackFail, toFail, failNow;

  assign newEn       = ctlWrEn ? ctlAnEn : anEn;
  assign restartReq  = linkLoss | (ctlWrEn & ctlRestart) | (ctlWrEn & ctlAnEn & ~anEn);
  assign anyIdle     = idle10 | idle100;
  assign negotiating = (st == ST_SEEK) || (st == ST_ACK);
  assign active      = newEn & ~restartReq & negotiating;
  assign timedOut    = timer >= TMR_W'(TIMEOUT_CYCLES - 1);

  assign cmd.cntSeek = active & (st == ST_SEEK) & ~anyIdle;
  assign cmd.cntAck  = active & (st == ST_ACK) & ~anyIdle;
  assign ackFail     = cmd.cntAck & runHit & ~hasCommon;
  assign toFail      = active & ~anyIdle & ~runHit & timedOut;
  assign failNow     = ackFail | toFail;
  assign cmd.restart = ~newEn | restartReq | failNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      anEn         <= 1'b1;
      st           <= ST_SEEK;
      timer        <= '0;
      negDone      <= 1'b0;
      negFail      <= 1'b0;
      linkSpeed100 <= 1'b0;
      linkFull     <= 1'b0;
    end else begin
      anEn <= newEn;
      if (!newEn || restartReq) begin
        st           <= newEn ? ST_SEEK : ST_OFF;
        timer        <= '0;
        negDone      <= 1'b0;
        negFail      <= 1'b0;
        linkSpeed100 <= 1'b0;
        linkFull     <= 1'b0;
      end else if (negotiating) begin
        if (anyIdle) begin
          st           <= ST_DONE;
          negDone      <= 1'b1;
          negFail      <= 1'b0;
          linkSpeed100 <= idle100;
          linkFull     <= 1'b0;
        end else if (runHit && st == ST_ACK) begin
          if (hasCommon) begin
            st           <= ST_DONE;
            negDone      <= 1'b1;
            negFail      <= 1'b0;
            linkSpeed100 <= best100;
            linkFull     <= bestFull;
          end else begin
            st      <= ST_SEEK;
            negFail <= 1'b1;
            timer   <= '0;
          end
        end else if (runHit) begin
          st    <= ST_ACK;
          timer <= timer + TMR_W'(1);
        end else if (timedOut) begin
          st      <= ST_SEEK;
          negFail <= 1'b1;
          timer   <= '0;
        end else begin
          timer <= timer + TMR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/linkNegArbiter.sv
module linkNegArbiter
  import lnkNegPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int RUN_LEN = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  strap,
  input  logic        ctlWrEn,
  input  logic        ctlAnEn,
  input  logic        ctlRestart,
  input  logic        advWrEn,
  input  logic [3:0]  advWrData,
  input  logic        rxWordValid,
  input  logic [15:0] rxWord,
  input  logic        idle10,
  input  logic        idle100,
  input  logic        linkLoss,
  output logic [15:0] txWord,
  output logic [15:0] partnerWord,
  output logic        negDone,
  output logic        negFail,
  output logic        linkSpeed100,
  output logic        linkFull
);
  dpCmd_t cmd;
  logic   runHit, hasCommon, best100, bestFull;

  lnkNegCtrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlAnEn(ctlAnEn),
    .ctlRestart(ctlRestart), .linkLoss(linkLoss), .idle10(idle10),
    .idle100(idle100), .runHit(runHit), .hasCommon(hasCommon),
    .best100(best100), .bestFull(bestFull), .cmd(cmd), .negDone(negDone),
    .negFail(negFail), .linkSpeed100(linkSpeed100), .linkFull(linkFull)
  );

  lnkNegData #(.RUN_LEN(RUN_LEN)) uData (
    .clk(clk), .rstN(rstN), .strap(strap), .advWrEn(advWrEn),
    .advWrData(advWrData), .rxWordValid(rxWordValid), .rxWord(rxWord),
    .cmd(cmd), .runHit(runHit), .hasCommon(hasCommon), .best100(best100),
    .bestFull(bestFull), .txWord(txWord), .partnerWord(partnerWord)
  );
endmodule

// File: rtl/linkNegArbiterChecker.sv
module linkNegArbiterChecker (
  input logic        clk,
  input logic        rstN,
  input logic        idle10,
  input logic        idle100,
  input logic        linkLoss,
  input logic [15:0] txWord,
  input logic        negDone,
  input logic        negFail,
  input logic        linkFull
);
  p_done_fail_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(negDone && negFail));

  p_adv_clear_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txWord[8:5] & ~$past(txWord[8:5])) == 4'b0000);

  p_ack_before_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(negDone) && !$past(idle10) && !$past(idle100)) |-> $past(txWord[14]));

  p_idle_half_r7: assert property (@(posedge clk) disable iff (!rstN)
    (negDone && !txWord[14]) |-> !linkFull);

  p_loss_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    linkLoss |=> (!negDone && !negFail && !txWord[14]));
endmodule

bind linkNegArbiter linkNegArbiterChecker uChk (.*);

// File: tb/linkNegArbiter_test.sv
module linkNegArbiter_test;
  localparam int TO = 60;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  strap = 3'b111;
  logic        ctlWrEn = 0, ctlAnEn = 0, ctlRestart = 0;
  logic        advWrEn = 0;
  logic [3:0]  advWrData = 0;
  logic        rxWordValid = 0;
  logic [15:0] rxWord = 0;
  logic        idle10 = 0, idle100 = 0, linkLoss = 0;
  logic [15:0] txWord, partnerWord;
  logic        negDone, negFail, linkSpeed100, linkFull;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  linkNegArbiter #(.TIMEOUT_CYCLES(TO)) uut (.*);

  // behavioural reference state
  bit          mEn, mDone, mFail, mSpd, mFull, mAck;
  int          mSt;  // 0 off, 1 phase one, 2 phase two, 3 done
  int          mTimer;
  logic [15:0] mPartner;
  logic [3:0]  mAdv;
  logic [15:0] mRun[$];

  function automatic logic [15:0] mkWord(input logic [3:0] ab, input logic ack);
    return {1'b0, ack, 5'b0, ab, 5'b00001};
  endfunction

  function automatic logic [3:0] seed(input logic [2:0] s);
    logic [3:0] r = 4'b0000;
    if (s[0]) r[0] = 1;
    if (s[0] && s[1]) r[1] = 1;
    if (s[2]) r[2] = 1;
    if (s[2] && s[1]) r[3] = 1;
    return r;
  endfunction

  task automatic clearNeg();
    mTimer = 0; mPartner = 0; mAck = 0; mRun.delete();
  endtask

  task automatic modelStep();
    bit newEn, rst, idle, hit;
    logic [3:0] c;
    if (!rstN) begin
      mEn = 1; mSt = 1; mDone = 0; mFail = 0; mSpd = 0; mFull = 0;
      mAdv = seed(strap); clearNeg();
      return;
    end
    if (advWrEn) mAdv = mAdv & advWrData;
    newEn = ctlWrEn ? ctlAnEn : mEn;
    rst = linkLoss || (ctlWrEn && ctlRestart) || (ctlWrEn && ctlAnEn && !mEn);
    mEn = newEn;
    idle = idle10 || idle100;
    if (!newEn || rst) begin
      mSt = newEn ? 1 : 0; mDone = 0; mFail = 0; mSpd = 0; mFull = 0; clearNeg();
      return;
    end
    if (mSt != 1 && mSt != 2) return;
    if (idle) begin
      mSt = 3; mDone = 1; mFail = 0; mSpd = idle100; mFull = 0;
      return;
    end
    hit = 0;
    if (rxWordValid) begin
      if (mSt == 2 && !rxWord[14]) mRun.delete();
      else begin
        if (mRun.size() > 0 && ((mRun[$] ^ rxWord) & 16'hBFFF) == 0) mRun.push_back(rxWord);
        else begin mRun.delete(); mRun.push_back(rxWord); end
        if (mRun.size() == 3) begin hit = 1; mRun.delete(); end
      end
    end
    if (hit && mSt == 2) begin
      c = mAdv & mPartner[8:5];
      if (c != 0) begin
        mSt = 3; mDone = 1; mFail = 0;
        mSpd = c[3] | c[2];
        mFull = c[3] | (!c[2] & c[1]);
      end else begin
        mSt = 1; mFail = 1; clearNeg();
      end
    end else if (hit) begin
      mSt = 2; mPartner = rxWord; mAck = 1; mTimer++;
    end else if (mTimer >= TO - 1) begin
      mSt = 1; mFail = 1; clearNeg();
    end else mTimer++;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R2/R3/R4 txWord", txWord, mkWord(mAdv, mAck));
    chk("R4/R5 partnerWord", partnerWord, mPartner);
    chk("R6/R7/R10/R11 negDone", {15'b0, negDone}, {15'b0, mDone});
    chk("R8/R9 negFail", {15'b0, negFail}, {15'b0, mFail});
    chk("R6/R7 result", {14'b0, linkSpeed100, linkFull}, {14'b0, mSpd, mFull});
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic sendWord(input logic [15:0] w);
    rxWordValid = 1; rxWord = w; tick();
    rxWordValid = 0; tick();
  endtask

  task automatic restartWr();
    ctlWrEn = 1; ctlAnEn = 1; ctlRestart = 1; tick();
    ctlWrEn = 0; ctlRestart = 0; tick();
  endtask

  task automatic negotiate(input logic [3:0] ab);
    for (int i = 0; i < 3; i++) sendWord(mkWord(ab, 0));
    for (int i = 0; i < 3; i++) sendWord(mkWord(ab, 1));
  endtask

  task automatic doReset(input logic [2:0] s);
    rstN = 0; strap = s;
    tick(); tick();
    rstN = 1;
    tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset(3'b111);
    // R1 R2: reset state and strap 111 seed
    chk("R1 idle after reset", {14'b0, negDone, negFail}, 16'h0000);
    chk("R2 strap 111 txWord", txWord, 16'h01E1);

    // R4 then R6: partner offers 100 half and 10 full
    for (int i = 0; i < 3; i++) sendWord(mkWord(4'b0110, 0));
    chk("R4 partner latched", partnerWord, mkWord(4'b0110, 0));
    chk("R4 ack on", {15'b0, txWord[14]}, 16'h0001);
    for (int i = 0; i < 3; i++) sendWord(mkWord(4'b0110, 1));
    chk("R6 done 100 half", {13'b0, negDone, linkSpeed100, linkFull}, 16'h0006);

    // R10: link loss clears result
    linkLoss = 1; tick(); linkLoss = 0;
    chk("R10 link loss clears", {13'b0, negDone, txWord[14], partnerWord != 0}, 16'h0000);

    // R5: broken run restarts the count
    sendWord(mkWord(4'b1000, 0)); sendWord(mkWord(4'b1000, 0));
    sendWord(mkWord(4'b0100, 0)); sendWord(mkWord(4'b0100, 0));
    chk("R5 no latch after broken run", partnerWord, 16'h0000);
    sendWord(mkWord(4'b0100, 0));
    chk("R5 latch after new run", partnerWord, mkWord(4'b0100, 0));
    // second-phase word without acknowledge resets the run
    sendWord(mkWord(4'b0100, 1)); sendWord(mkWord(4'b0100, 1));
    sendWord(mkWord(4'b0100, 0)); sendWord(mkWord(4'b0100, 1));
    chk("R6 not done after non-ack word", {15'b0, negDone}, 16'h0000);
    sendWord(mkWord(4'b0100, 1)); sendWord(mkWord(4'b0100, 1));
    chk("R6 done 100 half after rerun", {13'b0, negDone, linkSpeed100, linkFull}, 16'h0006);

    // R6 priority cases
    restartWr(); negotiate(4'b1111);
    chk("R6 100 full", {13'b0, negDone, linkSpeed100, linkFull}, 16'h0007);
    restartWr(); negotiate(4'b0011);
    chk("R6 10 full", {13'b0, negDone, linkSpeed100, linkFull}, 16'h0005);
    restartWr(); negotiate(4'b0001);
    chk("R6 10 half", {13'b0, negDone, linkSpeed100, linkFull}, 16'h0004);

    // R7: idle detection
    restartWr(); idle10 = 1; tick(); idle10 = 0;
    chk("R7 idle10 half", {13'b0, negDone, linkSpeed100, linkFull}, 16'h0004);
    restartWr(); idle10 = 1; idle100 = 1; tick(); idle10 = 0; idle100 = 0;
    chk("R7 idle100 wins", {13'b0, negDone, linkSpeed100, linkFull}, 16'h0006);

    // R8: no shared ability
    restartWr(); negotiate(4'b0000);
    chk("R8 fail no common", {14'b0, negDone, negFail}, 16'h0001);
    chk("R8 ack cleared", {15'b0, txWord[14]}, 16'h0000);

    // R9: timeout
    restartWr();
    for (int i = 0; i < TO - 2; i++) tick();
    chk("R9 not yet failed", {15'b0, negFail}, 16'h0000);
    tick(); tick();
    chk("R9 timeout fail", {15'b0, negFail}, 16'h0001);
    for (int i = 0; i < 10; i++) tick();

    // R11: disable ignores words and idles
    ctlWrEn = 1; ctlAnEn = 0; tick(); ctlWrEn = 0;
    negotiate(4'b1111); idle100 = 1; tick(); idle100 = 0;
    for (int i = 0; i < TO + 5; i++) tick();
    chk("R11 disabled ignores", {13'b0, negDone, negFail, txWord[14]}, 16'h0000);
    chk("R11 no partner", partnerWord, 16'h0000);
    ctlWrEn = 1; ctlAnEn = 1; tick(); ctlWrEn = 0;
    negotiate(4'b1000);
    chk("R11 re-enable negotiates", {13'b0, negDone, linkSpeed100, linkFull}, 16'h0007);

    // R3: clear-only advertisement writes
    advWrEn = 1; advWrData = 4'b1101; tick();
    advWrData = 4'b1111; tick(); advWrEn = 0; tick();
    chk("R3 bit stays cleared", {12'b0, txWord[8:5]}, 16'h000D);

    // R2: strap 001 seed
    doReset(3'b001);
    chk("R2 strap 001 txWord", txWord, 16'h0021);
    chk("R1 reset clears result", {13'b0, negDone, linkSpeed100, linkFull}, 16'h0000);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule